// File: doc/BRIEF.md
# Triggered Front-End Readout Emulator

This block stands in for the readout half of a tracking front-end chip. A vector of live hit flags is presented on its input every clock. A serial trigger line carries 3-bit commands; when the block recognises the level-1 accept pattern, it waits a programmable number of clocks. It then freezes the hit vector, together with an event number and a bunch counter, into a small readout queue.

A serializer drains the queue oldest first. Each event leaves as one fixed-length packet, one bit per clock and most significant bit first, on a single data line. A companion valid line is high for exactly the bits of the packet. Both outputs are updated on the falling clock edge, so a receiver running on the same clock can sample them on the rising edge.

The latency is loaded through a simple write strobe and data bus. A sticky overflow output reports that an accept found the queue full and was discarded.

Top module: `rdo_readout_emu`

## Requirements
- R1: The trigger line is sampled on rising edges. When no command is in progress, a 1 starts a 3-bit frame made of that bit and the next two. Only the frame 1,0,0 is an accept. The frames 1,0,1 / 1,1,0 / 1,1,1 produce no packet and leave the event number unchanged.
- R2: A write strobe loads an 8-bit latency L (0 to 255). The hit snapshot is taken at the rising edge L+1 clocks after the edge that samples the last bit of an accept.
- R3: The 128-bit hit field equals the hit input sampled at the capture edge. The 4-bit bunch field equals the number of rising edges since reset was released, counted before the capture edge, modulo 16.
- R4: A packet is 176 bits, sent MSB first: header 1010, 12-bit event number, 4-bit bunch field, 12-bit chip identity 0xC5A, 128 hit bits (bit 127 first), and a 16-bit check word. The check word is the XOR of the ten 16-bit slices of the first 160 bits.
- R5: The event number is 0 for the first accept after reset. It grows by one for every accept, including dropped ones.
- R6: Data and valid change only on falling edges. With an empty queue and an idle serializer, the first packet bit is present from the falling edge that follows the edge after capture. Valid stays high for exactly 176 bits.
- R7: Queued events leave in capture order, with exactly one valid-low bit time between consecutive packets.
- R8: The queue holds 4 waiting events; the head leaves the queue when its transmission begins. An accept captured while 4 events wait is discarded and sets the overflow output, which then stays high until reset.
- R9: A capture and the start of a transmission in the same cycle both take effect, and no event is lost or duplicated.
- R10: A synchronous active-high reset empties the queue, aborts any packet, and drives data, valid and overflow low. It also clears the latency, event number and bunch counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| trigIn | input | 1 | Serial trigger command line |
| hitIn | input | 128 | Live hit flags |
| latWrEn | input | 1 | Latency write strobe |
| latWrData | input | 8 | Latency value in clocks |
| dataOut | output | 1 | Serial packet data, falling-edge updated |
| dataValid | output | 1 | High while packet bits are on dataOut |
| overflowFlag | output | 1 | Sticky queue-full drop indicator |

## Verification
Capture into the queue and the pop that starts a new transmission can fall on the same rising edge. The bench forces this overlap by sending two accepts back to back and timing a third one so that its capture lands on the edge where the second packet is loaded. It passes only if all three packets come out in order, each with its own hits, event number and bunch field, and with one-bit gaps between them. A second overlap is checked as well: a capture that meets a full queue must be dropped while transmission continues undisturbed.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic capture;  // take a hit snapshot this cycle
    logic load;     // pop queue head into the shifter
    logic send;     // shifter is presenting a packet
  } rdoStrobes_t;

  localparam int unsigned CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_ACCEPT = 3'b100;
endpackage

// File: rtl/rdo_ctrl.sv
module rdo_ctrl
  import rdo_pkg::*;
#(
  parameter int LAT_W = 8,
  parameter int PKT_W = 176
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigIn,
  input  logic             latWrEn,
  input  logic [LAT_W-1:0] latWrData,
  input  logic             qEmpty,
  output rdoStrobes_t      strb
);
  localparam int MAX_LAT = (1 << LAT_W) - 1;
  localparam int CNT_W   = $clog2(PKT_W);
  localparam int POS_W   = $clog2(CMD_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PKT_W - 1);

  // Command deframer
  logic [CMD_W-2:0] cmdShift;
  logic [POS_W-1:0] cmdPos;
  logic             cmdBusy;
  logic             acceptPulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdShift    <= '0;
      cmdPos      <= '0;
      cmdBusy     <= 1'b0;
      acceptPulse <= 1'b0;
    end else begin
      acceptPulse <= 1'b0;
      if (!cmdBusy) begin
        if (trigIn) begin
          cmdBusy  <= 1'b1;
          cmdPos   <= POS_W'(1);
          cmdShift <= (CMD_W-1)'(1);
        end
      end else if (cmdPos == LAST_POS) begin
        cmdBusy     <= 1'b0;
        cmdPos      <= '0;
        acceptPulse <= ({cmdShift, trigIn} == CMD_ACCEPT);
      end else begin
        cmdPos   <= cmdPos + 1'b1;
        cmdShift <= {cmdShift[CMD_W-3:0], trigIn};
      end
    end
  end

  // Latency register and delay line
  logic [LAT_W-1:0] latReg;
  logic [MAX_LAT:1] latPipe;
  logic             captureNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      latReg  <= '0;
      latPipe <= '0;
    end else begin
      if (latWrEn) latReg <= latWrData;
      latPipe <= {latPipe[MAX_LAT-1:1], acceptPulse};
    end
  end

  always_comb begin
    if (latReg == '0) captureNow = acceptPulse;
    else              captureNow = latPipe[latReg];
  end

  // Serializer sequencing
  logic             active;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (!active) begin
      if (!qEmpty) begin
        active <= 1'b1;
        bitCnt <= '0;
      end
    end else if (bitCnt == LAST_BIT) begin
      active <= 1'b0;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strb.capture = captureNow;
    strb.load    = !active && !qEmpty;
    strb.send    = active;
  end

  // Accepts are at least one frame apart (R1)
  assert_accept_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    acceptPulse |=> !acceptPulse);

  // Last bit is followed by an idle bit time (R7)
  assert_packet_gap_R7: assert property (@(posedge clk) disable iff (rst)
    (active && bitCnt == LAST_BIT) |=> !active);

  // A load starts a packet at bit zero (R6)
  assert_load_start_R6: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (active && bitCnt == '0));
endmodule

// File: rtl/rdo_datapath.sv
module rdo_datapath
  import rdo_pkg::*;
#(
  parameter int HIT_W  = 128,
  parameter int EVT_W  = 12,
  parameter int BC_W   = 4,
  parameter int ID_W   = 12,
  parameter int HDR_W  = 4,
  parameter int CHK_W  = 16,
  parameter int QDEPTH = 4,
  parameter logic [ID_W-1:0]  CHIP_ID = 'hC5A,
  parameter logic [HDR_W-1:0] HEADER  = 'hA
) (
  input  logic             clk,
  input  logic             rst,
  input  rdoStrobes_t      strb,
  input  logic [HIT_W-1:0] hitIn,
  output logic             qEmpty,
  output logic             dataOut,
  output logic             dataValid,
  output logic             overflowFlag
);
  localparam int REC_W  = EVT_W + BC_W + HIT_W;
  localparam int BODY_W = HDR_W + EVT_W + BC_W + ID_W + HIT_W;
  localparam int PKT_W  = BODY_W + CHK_W;
  localparam int NSLICE = BODY_W / CHK_W;
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int QCNT_W = $clog2(QDEPTH + 1);
  localparam logic [QCNT_W-1:0] QFULL_CNT = QCNT_W'(QDEPTH);
  localparam logic [PTR_W-1:0]  LAST_PTR  = PTR_W'(QDEPTH - 1);

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  logic [REC_W-1:0]  qMem [QDEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [QCNT_W-1:0] qCount;
  logic [EVT_W-1:0]  evtCnt;
  logic [BC_W-1:0]   bcCnt;
  logic              qFull, doPush, doPop;

  assign qFull  = (qCount == QFULL_CNT);
  assign qEmpty = (qCount == '0);
  assign doPush = strb.capture && !qFull;
  assign doPop  = strb.load;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      qCount       <= '0;
      evtCnt       <= '0;
      bcCnt        <= '0;
      overflowFlag <= 1'b0;
    end else begin
      bcCnt <= bcCnt + 1'b1;
      if (strb.capture) begin
        evtCnt <= evtCnt + 1'b1;
        if (qFull) overflowFlag <= 1'b1;
      end
      if (doPush) begin
        qMem[wrPtr] <= {evtCnt, bcCnt, hitIn};
        wrPtr       <= bumpPtr(wrPtr);
      end
      if (doPop) rdPtr <= bumpPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  // Packet assembly from the queue head
  logic [REC_W-1:0]  headRec;
  logic [BODY_W-1:0] body;
  logic [CHK_W-1:0]  chk;

  assign headRec = qMem[rdPtr];
  assign body = {HEADER, headRec[REC_W-1 -: EVT_W], headRec[HIT_W+BC_W-1 -: BC_W],
                 CHIP_ID, headRec[HIT_W-1:0]};

  always_comb begin
    chk = '0;
    for (int k = 0; k < NSLICE; k++) chk ^= body[k*CHK_W +: CHK_W];
  end

  // Shifter and falling-edge output stage
  logic [PKT_W-1:0] txShift;

  always_ff @(posedge clk) begin
    if (rst)            txShift <= '0;
    else if (strb.load) txShift <= {body, chk};
    else if (strb.send) txShift <= {txShift[PKT_W-2:0], 1'b0};
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      dataOut   <= 1'b0;
      dataValid <= 1'b0;
    end else begin
      dataOut   <= strb.send & txShift[PKT_W-1];
      dataValid <= strb.send;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    qCount <= QFULL_CNT);

  // A capture into a full queue with no pop leaves it full (R8)
  assert_drop_full_R8: assert property (@(posedge clk) disable iff (rst)
    (strb.capture && qFull && !strb.load) |=> qFull);

  assert_sticky_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    overflowFlag |=> overflowFlag);

  assert_event_step_R5: assert property (@(posedge clk) disable iff (rst)
    strb.capture |=> (evtCnt == EVT_W'($past(evtCnt) + 1'b1)));
endmodule

// File: rtl/rdo_readout_emu.sv
module rdo_readout_emu
  import rdo_pkg::*;
#(
  parameter int HIT_W  = 128,
  parameter int EVT_W  = 12,
  parameter int BC_W   = 4,
  parameter int ID_W   = 12,
  parameter int HDR_W  = 4,
  parameter int CHK_W  = 16,
  parameter int LAT_W  = 8,
  parameter int QDEPTH = 4,
  parameter logic [ID_W-1:0]  CHIP_ID = 'hC5A,
  parameter logic [HDR_W-1:0] HEADER  = 'hA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigIn,
  input  logic [HIT_W-1:0] hitIn,
  input  logic             latWrEn,
  input  logic [LAT_W-1:0] latWrData,
  output logic             dataOut,
  output logic             dataValid,
  output logic             overflowFlag
);
  localparam int PKT_W = HDR_W + EVT_W + BC_W + ID_W + HIT_W + CHK_W;

  rdoStrobes_t strb;
  logic        qEmpty;

  rdo_ctrl #(.LAT_W(LAT_W), .PKT_W(PKT_W)) ctrl_i (
    .clk(clk), .rst(rst), .trigIn(trigIn), .latWrEn(latWrEn),
    .latWrData(latWrData), .qEmpty(qEmpty), .strb(strb)
  );

  rdo_datapath #(
    .HIT_W(HIT_W), .EVT_W(EVT_W), .BC_W(BC_W), .ID_W(ID_W), .HDR_W(HDR_W),
    .CHK_W(CHK_W), .QDEPTH(QDEPTH), .CHIP_ID(CHIP_ID), .HEADER(HEADER)
  ) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .hitIn(hitIn), .qEmpty(qEmpty),
    .dataOut(dataOut), .dataValid(dataValid), .overflowFlag(overflowFlag)
  );
endmodule

// File: tb/rdo_readout_emu_tb_top.sv
module rdo_readout_emu_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         trigIn;
  logic [127:0] hitIn;
  logic         latWrEn;
  logic [7:0]   latWrData;
  logic         dataOut, dataValid, overflowFlag;

  rdo_readout_emu dut_i (
    .clk(clk), .rst(rst), .trigIn(trigIn), .hitIn(hitIn), .latWrEn(latWrEn),
    .latWrData(latWrData), .dataOut(dataOut), .dataValid(dataValid),
    .overflowFlag(overflowFlag)
  );

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int cyc = 0;
  int curLat = 0, evtNext = 0, validSeen = 0;
  int expEvt[$], expCap[$], expMode[$];   // mode 1: absolute start, 2: chained

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic logic [127:0] hitFn(input int c);
    logic [31:0] u;
    u = c;
    return {u * 32'h9E3779B1, ~(u * 32'h01000193), u ^ 32'h5A5AA5A5,
            {u[15:0], u[15:0]} ^ 32'h0F0F3C3C};
  endfunction

  function automatic logic [175:0] mkPkt(input int evt, input int cap);
    logic [159:0] body;
    logic [15:0]  chk;
    logic [31:0]  eu, cu;
    eu = evt;
    cu = cap;
    body = {4'hA, eu[11:0], cu[3:0], 12'hC5A, hitFn(cap)};
    chk = '0;
    for (int k = 0; k < 10; k++) chk ^= body[k*16 +: 16];
    return {body, chk};
  endfunction

  always @(negedge clk) hitIn = hitFn(cyc);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [175:0] act, input logic [175:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Receiver: samples just after the rising edge
  logic [175:0] rxShift;
  int rxCnt = 0, rxStart = 0, prevLow = 0;
  always @(posedge clk) begin
    #1;
    if (rst) begin
      rxCnt = 0;
    end else if (dataValid) begin
      if (rxCnt == 0) rxStart = cyc;
      rxShift = {rxShift[174:0], dataOut};
      rxCnt++;
      validSeen++;
    end else if (rxCnt != 0) begin
      check(rxCnt == 176, "R6", "valid length", 176'(rxCnt), 176'd176);
      if (expEvt.size() == 0) begin
        check(1'b0, "R7", "unexpected packet", rxShift, '0);
      end else begin
        int e, c, m;
        e = expEvt.pop_front();
        c = expCap.pop_front();
        m = expMode.pop_front();
        check(rxShift == mkPkt(e, c), "R3 R4 R5", "packet content", rxShift, mkPkt(e, c));
        if (m == 1)
          check(rxStart == c + 3, "R2 R6", "first bit timing", 176'(rxStart), 176'(c + 3));
        else
          check(rxStart == prevLow + 1, "R7 R9", "chained start", 176'(rxStart), 176'(prevLow + 1));
      end
      prevLow = cyc;
      rxCnt = 0;
    end
  end

  task automatic setLat(input int l);
    @(negedge clk);
    latWrEn = 1'b1;
    latWrData = 8'(l);
    @(negedge clk);
    latWrEn = 1'b0;
    curLat = l;
  endtask

  // Drive a 3-bit frame; startAt >= 0 waits for that cycle count first
  task automatic sendCmd(input logic [2:0] cmd, input int startAt, output int cLast);
    @(negedge clk);
    if (startAt >= 0) while (cyc != startAt) @(negedge clk);
    trigIn = cmd[2];
    @(negedge clk) trigIn = cmd[1];
    @(negedge clk) trigIn = cmd[0];
    cLast = cyc;
  endtask

  task automatic expectEvt(input int cLast, input int mode);
    expEvt.push_back(evtNext);
    expCap.push_back(cLast + 1 + curLat);
    expMode.push_back(mode);
    evtNext++;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trigIn = 1'b0;
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (expEvt.size() != 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    check(expEvt.size() == 0, "R7", "packets outstanding", 176'(expEvt.size()), '0);
    quiet(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c, ca, v0;
    int lats[12] = '{0, 1, 2, 3, 4, 5, 15, 16, 17, 100, 254, 255};
    rst = 1'b1; trigIn = 1'b0; latWrEn = 1'b0; latWrData = '0;
    repeat (5) @(negedge clk);
    check(!dataValid && !dataOut && !overflowFlag, "R10", "reset outputs",
          176'({dataValid, dataOut, overflowFlag}), '0);
    rst = 1'b0;

    // R2 R3 R6: latency sweep, each capture at a different cycle
    foreach (lats[i]) begin
      setLat(lats[i]);
      sendCmd(3'b100, -1, c);
      expectEvt(c, 1);
      quiet(1);
      drain();
    end

    // R1: non-accept frames, including a misaligned 1,1,0,0
    v0 = validSeen;
    setLat(0);
    sendCmd(3'b101, -1, c);
    sendCmd(3'b110, -1, c);
    sendCmd(3'b111, -1, c);
    quiet(1);
    sendCmd(3'b110, -1, c);
    quiet(300);
    check(validSeen == v0, "R1", "no packet from other frames", 176'(validSeen), 176'(v0));

    // R8: six accepts back to back, sixth dropped
    check(!overflowFlag, "R8", "overflow clear before", 176'(overflowFlag), '0);
    for (int i = 0; i < 6; i++) begin
      sendCmd(3'b100, -1, c);
      if (i < 5) expectEvt(c, (i == 0) ? 1 : 2);
      else begin
        check(!overflowFlag, "R8", "no overflow with room", 176'(overflowFlag), '0);
        evtNext++;
      end
    end
    quiet(2);
    check(overflowFlag, "R8", "overflow on drop", 176'(overflowFlag), 176'd1);
    drain();
    check(overflowFlag, "R8", "overflow sticky", 176'(overflowFlag), 176'd1);

    // R9: capture on the same edge as the second pop
    sendCmd(3'b100, -1, ca);
    expectEvt(ca, 1);
    sendCmd(3'b100, -1, c);
    expectEvt(c, 2);
    sendCmd(3'b100, ca + 176, c);
    check(c == ca + 178, "R9", "collision aligned", 176'(c), 176'(ca + 178));
    expectEvt(c, 2);
    quiet(1);
    drain();

    // R10: reset during transmission with events waiting
    setLat(5);
    for (int i = 0; i < 3; i++) sendCmd(3'b100, -1, c);
    quiet(60);
    rst = 1'b1;
    expEvt.delete(); expCap.delete(); expMode.delete();
    repeat (3) @(negedge clk);
    check(!dataValid && !overflowFlag, "R10", "outputs in reset",
          176'({dataValid, overflowFlag}), '0);
    rst = 1'b0;
    evtNext = 0;
    curLat = 0;
    v0 = validSeen;
    quiet(400);
    check(validSeen == v0, "R10", "queue emptied", 176'(validSeen), 176'(v0));
    check(!overflowFlag, "R10", "overflow cleared", 176'(overflowFlag), '0);
    sendCmd(3'b100, -1, c);
    expectEvt(c, 1);
    quiet(1);
    drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule